// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame is kept, based on the frame's 48-bit destination address. A start pulse hands it the address, the frame length, the station address, a 64-entry hash table (two 32-bit halves) and a set of mode bits. It then reports whether the frame is forwarded and builds the filter part of the receive status word.

A frame can be accepted in several ways. Promiscuous mode keeps everything. An all-ones address is a broadcast, which is gated by its own block bit. Multicast frames can be passed wholesale. Otherwise unicast and multicast frames each choose, through their own mode bit, between an exact compare with the station address (optionally inverted) and a lookup in the hash table. The hash index comes from a CRC-32 of the address, which the block computes itself, one byte per cycle. A keep-all bit forwards frames that the filter rejected, and the status word flags them. Frame storage, the FCS check of the whole frame and register programming belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, done_o, forward_o and status_o are all 0.
- R2: The edge that samples start_i high in the idle state starts a lookup. done_o goes high for exactly one cycle after the 7th rising edge following that edge, and forward_o and status_o are valid from then on. They hold their values until the next done_o pulse.
- R3: With promisc_i set, every address is forwarded and status bit 30 is 0, including a broadcast while bcast_block_i is set.
- R4: An address of all ones is a broadcast. Without promiscuous mode it passes only when bcast_block_i is 0. Status bit 13 is 1 for a broadcast, and bit 10 is then 0.
- R5: Address byte k sits at dst_addr_i[8k+7:8k], and byte 0 is the first byte on the wire. An address is multicast when dst_addr_i[0] is 1. A non-broadcast multicast sets status bit 10, and with all_mcast_i set it passes without further checks.
- R6: A unicast address with uc_hash_i at 0, or a multicast address with mc_hash_i at 0, passes only if it equals station_addr_i (same byte layout).
- R7: With invert_i set, the result of the exact compare is inverted. invert_i has no effect on a hash lookup.
- R8: With uc_hash_i set (unicast) or mc_hash_i set (multicast), the address passes only when the hash table bit it selects is 1. The CRC register is preset to all ones. Bytes 0 to 5 are fed in order, each least-significant bit first, with the reflected polynomial 0xEDB88320 and no final inversion. The index is CRC bits 31:26. Index bit 5 picks hash_hi_i (1) or hash_lo_i (0), and index bits 4:0 pick the bit within that word.
- R9: Status bit 30 is 1 exactly when the filter rejected the address. forward_o is 1 when the filter passed the address, or when keep_all_i is set.
- R10: status_o[29:16] holds frame_len_i + 4, modulo 2^14. Bits 31, 15:14, 12:11 and 9:0 are 0.
- R11: start_i is ignored while a lookup is in progress. The result is the one for the inputs sampled at the accepted start, and no extra done_o pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a lookup; sampled only when idle |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len_i | input | LEN_W | Frame length in bytes |
| station_addr_i | input | 48 | Own address for exact match |
| hash_hi_i | input | 32 | Hash table entries 32 to 63 |
| hash_lo_i | input | 32 | Hash table entries 0 to 31 |
| promisc_i | input | 1 | Accept every address |
| bcast_block_i | input | 1 | Reject broadcast frames |
| all_mcast_i | input | 1 | Accept every multicast address |
| uc_hash_i | input | 1 | Unicast uses the hash table instead of exact match |
| mc_hash_i | input | 1 | Multicast uses the hash table instead of exact match |
| invert_i | input | 1 | Invert the exact-match result |
| keep_all_i | input | 1 | Forward frames the filter rejected |
| done_o | output | 1 | One-cycle pulse: result valid |
| forward_o | output | 1 | Frame is forwarded |
| status_o | output | 32 | Receive status word, filter fields |

## Verification
The bench builds the block with the default LEN_W of 14, so the length field is exactly as wide as the frame length input. This lets a length of 16379 reach the top code of the status length field, and a length of 16380 wraps the field to zero. For hash lookups the bench computes the CRC index of each address itself and programs a table with only that bit set, or with every bit except that one. This reaches both table halves and both lookup outcomes without needing precomputed CRC values. The bench also checks every lookup for the fixed latency and the single-cycle done pulse.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int ADDR_BYTES    = 6;
    localparam int ADDR_W        = 8 * ADDR_BYTES;
    localparam int CRC_W         = 32;
    localparam int HASH_IDX_W    = 6;
    localparam int TBL_W         = 32;
    localparam int STS_W         = 32;
    localparam int STS_LEN_LSB   = 16;
    localparam int STS_FAIL_BIT  = 30;
    localparam int STS_BCAST_BIT = 13;
    localparam int STS_MCAST_BIT = 10;
    localparam int STS_LEN_W     = STS_FAIL_BIT - STS_LEN_LSB;
    localparam int LEN_ADJUST    = 4;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

    typedef struct packed {
        logic promisc;
        logic bcast_block;
        logic all_mcast;
        logic uc_hash;
        logic mc_hash;
        logic invert;
        logic keep_all;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } seq_t;

    // One byte of a reflected CRC, least-significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] cur,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] r;
        r = cur ^ {{(CRC_W-8){1'b0}}, data};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxaf_crc_engine.sv
module rxaf_crc_engine
    import rxaf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (load_i) begin
            crc_d = '1;
        end else if (step_i) begin
            crc_d = crc_step_byte(crc_q, byte_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/rxaf_addr_class.sv
module rxaf_addr_class
    import rxaf_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES
) (
    input  logic [8*NBYTES-1:0] addr_i,
    input  logic [8*NBYTES-1:0] station_i,
    output logic                is_bcast_o,
    output logic                is_mcast_o,
    output logic                exact_o
);

    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_ones;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_eq[g]   = (addr_i[8*g +: 8] == station_i[8*g +: 8]);
        assign byte_ones[g] = &addr_i[8*g +: 8];
    end

    assign is_bcast_o = &byte_ones;
    assign is_mcast_o = addr_i[0];
    assign exact_o    = &byte_eq;

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
(
    input  mode_t                 mode_i,
    input  logic                  is_bcast_i,
    input  logic                  is_mcast_i,
    input  logic                  exact_i,
    input  logic [HASH_IDX_W-1:0] hash_idx_i,
    input  logic [TBL_W-1:0]      hash_hi_i,
    input  logic [TBL_W-1:0]      hash_lo_i,
    output logic                  pass_o
);

    logic [TBL_W-1:0] sel_word;
    logic             hash_hit;
    logic             perfect_ok;
    logic             use_hash;

    always_comb begin
        sel_word   = hash_idx_i[HASH_IDX_W-1] ? hash_hi_i : hash_lo_i;
        hash_hit   = sel_word[hash_idx_i[HASH_IDX_W-2:0]];
        perfect_ok = exact_i ^ mode_i.invert;
        use_hash   = is_mcast_i ? mode_i.mc_hash : mode_i.uc_hash;

        // Priority order is part of the behaviour.
        if (mode_i.promisc) begin
            pass_o = 1'b1;
        end else if (is_bcast_i) begin
            pass_o = !mode_i.bcast_block;
        end else if (is_mcast_i && mode_i.all_mcast) begin
            pass_o = 1'b1;
        end else if (use_hash) begin
            pass_o = hash_hit;
        end else begin
            pass_o = perfect_ok;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [47:0]       dst_addr_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic [47:0]       station_addr_i,
    input  logic [31:0]       hash_hi_i,
    input  logic [31:0]       hash_lo_i,
    input  logic              promisc_i,
    input  logic              bcast_block_i,
    input  logic              all_mcast_i,
    input  logic              uc_hash_i,
    input  logic              mc_hash_i,
    input  logic              invert_i,
    input  logic              keep_all_i,
    output logic              done_o,
    output logic              forward_o,
    output logic [31:0]       status_o
);

    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        seq_t               st;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  sta;
        logic [TBL_W-1:0]   hi;
        logic [TBL_W-1:0]   lo;
        mode_t              mode;
        logic [LEN_W-1:0]   len;
        logic               done;
        logic               fwd;
        logic [STS_W-1:0]   status;
    } regs_t;

    regs_t r_d, r_q;

    logic                  crc_load;
    logic                  crc_step;
    logic [7:0]            crc_byte;
    logic [CRC_W-1:0]      crc_val;
    logic                  is_bcast;
    logic                  is_mcast;
    logic                  exact;
    logic                  pass;
    logic [STS_LEN_W-1:0]  len_field;
    mode_t                 mode_in;

    logic                  busy_w;
    logic                  promisc_cap_w;

    assign mode_in = '{promisc:     promisc_i,
                       bcast_block: bcast_block_i,
                       all_mcast:   all_mcast_i,
                       uc_hash:     uc_hash_i,
                       mc_hash:     mc_hash_i,
                       invert:      invert_i,
                       keep_all:    keep_all_i};

    assign crc_byte  = r_q.addr[{r_q.cnt, 3'b000} +: 8];
    assign len_field = STS_LEN_W'(r_q.len) + STS_LEN_W'(LEN_ADJUST);

    rxaf_crc_engine u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (crc_load),
        .step_i (crc_step),
        .byte_i (crc_byte),
        .crc_o  (crc_val)
    );

    rxaf_addr_class #(.NBYTES(ADDR_BYTES)) u_class (
        .addr_i     (r_q.addr),
        .station_i  (r_q.sta),
        .is_bcast_o (is_bcast),
        .is_mcast_o (is_mcast),
        .exact_o    (exact)
    );

    rxaf_decide u_decide (
        .mode_i     (r_q.mode),
        .is_bcast_i (is_bcast),
        .is_mcast_i (is_mcast),
        .exact_i    (exact),
        .hash_idx_i (crc_val[CRC_W-1 -: HASH_IDX_W]),
        .hash_hi_i  (r_q.hi),
        .hash_lo_i  (r_q.lo),
        .pass_o     (pass)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        crc_load = 1'b0;
        crc_step = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_RUN;
                    r_d.cnt  = '0;
                    r_d.addr = dst_addr_i;
                    r_d.sta  = station_addr_i;
                    r_d.hi   = hash_hi_i;
                    r_d.lo   = hash_lo_i;
                    r_d.mode = mode_in;
                    r_d.len  = frame_len_i;
                    crc_load = 1'b1;
                end
            end
            ST_RUN: begin
                crc_step = 1'b1;
                if (r_q.cnt == LAST_BYTE) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_FIN: begin
                r_d.st     = ST_IDLE;
                r_d.done   = 1'b1;
                r_d.fwd    = pass | r_q.mode.keep_all;
                r_d.status = '0;
                r_d.status[STS_LEN_LSB +: STS_LEN_W] = len_field;
                r_d.status[STS_FAIL_BIT]  = !pass;
                r_d.status[STS_BCAST_BIT] = is_bcast;
                r_d.status[STS_MCAST_BIT] = is_mcast & !is_bcast;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o        = r_q.done;
    assign forward_o     = r_q.fwd;
    assign status_o      = r_q.status;
    assign busy_w        = (r_q.st != ST_IDLE);
    assign promisc_cap_w = r_q.mode.promisc;

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        done_o,
    input logic        forward_o,
    input logic [31:0] status_o,
    input logic        busy,
    input logic        promisc_cap
);

    // R2: a result pulse lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: an accepted start makes the block busy
    a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> busy);

    // R11: a lookup only leaves the busy state through a done pulse
    a_r11_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done_o));

    // R9: a dropped frame always carries the filter-fail flag
    a_r9_drop_is_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !forward_o) |-> status_o[30]);

    // R4: broadcast and multicast flags are exclusive
    a_r4_bcast_not_mcast: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o[13]) |-> !status_o[10]);

    // R3: promiscuous lookups always pass
    a_r3_promisc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && promisc_cap) |-> (forward_o && !status_o[30]));

endmodule

bind rx_addr_filter rxaf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .forward_o   (forward_o),
    .status_o    (status_o),
    .busy        (busy_w),
    .promisc_cap (promisc_cap_w)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;

    localparam int LEN_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [47:0]      dst_addr_i = '0;
    logic [LEN_W-1:0] frame_len_i = '0;
    logic [47:0]      station_addr_i = '0;
    logic [31:0]      hash_hi_i = '0;
    logic [31:0]      hash_lo_i = '0;
    logic             promisc_i = 1'b0;
    logic             bcast_block_i = 1'b0;
    logic             all_mcast_i = 1'b0;
    logic             uc_hash_i = 1'b0;
    logic             mc_hash_i = 1'b0;
    logic             invert_i = 1'b0;
    logic             keep_all_i = 1'b0;
    logic             done_o;
    logic             forward_o;
    logic [31:0]      status_o;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    logic        got_fwd;
    logic [31:0] got_sts;
    int          got_lat;

    always #10 clk = ~clk;

    rx_addr_filter #(.LEN_W(LEN_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .dst_addr_i     (dst_addr_i),
        .frame_len_i    (frame_len_i),
        .station_addr_i (station_addr_i),
        .hash_hi_i      (hash_hi_i),
        .hash_lo_i      (hash_lo_i),
        .promisc_i      (promisc_i),
        .bcast_block_i  (bcast_block_i),
        .all_mcast_i    (all_mcast_i),
        .uc_hash_i      (uc_hash_i),
        .mc_hash_i      (mc_hash_i),
        .invert_i       (invert_i),
        .keep_all_i     (keep_all_i),
        .done_o         (done_o),
        .forward_o      (forward_o),
        .status_o       (status_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    // Hash index per R8
    function automatic logic [5:0] hash_index(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            c = c ^ {24'd0, a[8*k +: 8]};
            for (int b = 0; b < 8; b++) begin
                if (c[0]) c = (c >> 1) ^ 32'hEDB8_8320;
                else      c = c >> 1;
            end
        end
        return c[31:26];
    endfunction

    // Filter decision per R3..R8
    function automatic logic model_pass(input logic [47:0] a);
        logic [5:0]  idx;
        logic [31:0] w;
        logic        mc;
        if (promisc_i) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return !bcast_block_i;
        mc = a[0];
        if (mc && all_mcast_i) return 1'b1;
        if (mc ? mc_hash_i : uc_hash_i) begin
            idx = hash_index(a);
            w = idx[5] ? hash_hi_i : hash_lo_i;
            return w[idx[4:0]];
        end
        return (a == station_addr_i) ^ invert_i;
    endfunction

    function automatic logic [31:0] model_status(input logic [47:0] a, input logic [LEN_W-1:0] len, input logic ok);
        logic [31:0] s;
        logic        bc;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        s = '0;
        s[29:16] = 14'(len + 14'd4);
        s[30] = !ok;
        s[13] = bc;
        s[10] = a[0] & !bc;
        return s;
    endfunction

    task automatic run_frame(input logic [47:0] a, input logic [LEN_W-1:0] len);
        @(negedge clk);
        dst_addr_i  = a;
        frame_len_i = len;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        got_lat = 1;
        while (!done_o && got_lat < 40) begin
            @(negedge clk);
            got_lat++;
        end
        got_fwd = forward_o;
        got_sts = status_o;
    endtask

    // Runs a lookup and checks forward, status, latency and pulse width (R2).
    task automatic check_frame(input string tag, input logic [47:0] a, input logic [LEN_W-1:0] len);
        logic ok;
        ok = model_pass(a);
        run_frame(a, len);
        chk({tag, " forward"}, {31'd0, got_fwd}, {31'd0, ok | keep_all_i});
        chk({tag, " status"}, got_sts, model_status(a, len, ok));
        chk({tag, " R2 latency"}, got_lat, 8);
        @(negedge clk);
        chk({tag, " R2 pulse width"}, {31'd0, done_o}, 32'd0);
        chk({tag, " R2 hold"}, status_o, got_sts);
    endtask

    task automatic clear_modes();
        promisc_i = 0; bcast_block_i = 0; all_mcast_i = 0;
        uc_hash_i = 0; mc_hash_i = 0; invert_i = 0; keep_all_i = 0;
        hash_hi_i = '0; hash_lo_i = '0;
    endtask

    task automatic t_reset();
        chk("R1 done at reset", {31'd0, done_o}, 32'd0);
        chk("R1 forward at reset", {31'd0, forward_o}, 32'd0);
        chk("R1 status at reset", status_o, 32'd0);
    endtask

    task automatic t_promisc();
        clear_modes();
        promisc_i = 1; bcast_block_i = 1;
        check_frame("R3 unicast mismatch", 48'h1234_5678_9A02, 14'd64);
        check_frame("R3 broadcast blocked bit", 48'hFFFF_FFFF_FFFF, 14'd60);
        chk("R3 forward", {31'd0, got_fwd}, 32'd1);
    endtask

    task automatic t_bcast();
        clear_modes();
        check_frame("R4 broadcast allowed", 48'hFFFF_FFFF_FFFF, 14'd100);
        chk("R4 bcast flag", {31'd0, got_sts[13]}, 32'd1);
        bcast_block_i = 1;
        check_frame("R4 broadcast blocked", 48'hFFFF_FFFF_FFFF, 14'd100);
        chk("R4 blocked forward", {31'd0, got_fwd}, 32'd0);
        check_frame("R4 near broadcast", 48'hFFFF_FFFF_FFFE, 14'd100);
    endtask

    task automatic t_perfect();
        clear_modes();
        station_addr_i = 48'h6655_4433_2200;
        check_frame("R6 unicast equal", 48'h6655_4433_2200, 14'd64);
        chk("R6 equal passes", {31'd0, got_fwd}, 32'd1);
        check_frame("R6 last byte differs", 48'h6755_4433_2200, 14'd64);
        chk("R6 differ rejected", {31'd0, got_fwd}, 32'd0);
        station_addr_i = 48'h0000_005E_0001;
        check_frame("R6 multicast equal", 48'h0000_005E_0001, 14'd80);
        chk("R5 mcast flag", {31'd0, got_sts[10]}, 32'd1);
        check_frame("R6 multicast differs", 48'h0100_005E_0001, 14'd80);
    endtask

    task automatic t_inverse();
        logic [5:0] idx;
        clear_modes();
        station_addr_i = 48'hA0B0_C0D0_E0F0;
        invert_i = 1;
        check_frame("R7 inverted equal", 48'hA0B0_C0D0_E0F0, 14'd64);
        chk("R7 equal now rejected", {31'd0, got_fwd}, 32'd0);
        check_frame("R7 inverted differ", 48'hA0B0_C0D0_E0F2, 14'd64);
        chk("R7 differ now passes", {31'd0, got_fwd}, 32'd1);
        uc_hash_i = 1;
        idx = hash_index(48'hA0B0_C0D0_E0F0);
        {hash_hi_i, hash_lo_i} = 64'd1 << idx;
        check_frame("R7 invert ignored for hash", 48'hA0B0_C0D0_E0F0, 14'd64);
        chk("R7 hash hit passes", {31'd0, got_fwd}, 32'd1);
    endtask

    task automatic t_mcast();
        clear_modes();
        station_addr_i = 48'h1111_1111_1110;
        all_mcast_i = 1;
        check_frame("R5 pass all multicast", 48'h0100_5E00_0001, 14'd90);
        chk("R5 passes", {31'd0, got_fwd}, 32'd1);
        all_mcast_i = 0;
        check_frame("R5 multicast no pass-all", 48'h0100_5E00_0001, 14'd90);
        chk("R5 rejected", {31'd0, got_fwd}, 32'd0);
    endtask

    task automatic t_hash();
        logic [47:0] a;
        logic [5:0]  idx;
        bit          seen_hi;
        bit          seen_lo;
        clear_modes();
        station_addr_i = 48'h0;
        seen_hi = 0; seen_lo = 0;
        for (int k = 1; k <= 8; k++) begin
            a = {8'(k * 37), 8'(k * 11), 8'(k * 5), 8'(k * 3), 8'(k * 7), 8'(k * 2)};
            a[0] = k[0];
            uc_hash_i = !a[0];
            mc_hash_i = a[0];
            idx = hash_index(a);
            if (idx[5]) seen_hi = 1; else seen_lo = 1;
            {hash_hi_i, hash_lo_i} = 64'd1 << idx;
            check_frame("R8 hash hit", a, 14'(64 + k));
            chk("R8 hit passes", {31'd0, got_fwd}, 32'd1);
            {hash_hi_i, hash_lo_i} = ~(64'd1 << idx);
            check_frame("R8 hash miss", a, 14'(64 + k));
            chk("R8 miss rejected", {31'd0, got_fwd}, 32'd0);
        end
        if (!(seen_hi && seen_lo)) $display("note: R8 address set reached one table half only");
    endtask

    task automatic t_rxall();
        clear_modes();
        station_addr_i = 48'h0102_0304_0506;
        keep_all_i = 1;
        check_frame("R9 keep rejected", 48'h0102_0304_0508, 14'd70);
        chk("R9 forwarded", {31'd0, got_fwd}, 32'd1);
        chk("R9 fail flag", {31'd0, got_sts[30]}, 32'd1);
        check_frame("R9 keep passing", 48'h0102_0304_0506, 14'd70);
        chk("R9 no fail flag", {31'd0, got_sts[30]}, 32'd0);
    endtask

    task automatic t_len();
        clear_modes();
        promisc_i = 1;
        check_frame("R10 zero length", 48'h0, 14'd0);
        check_frame("R10 typical length", 48'h0, 14'd1500);
        check_frame("R10 top of field", 48'h0, 14'd16379);
        chk("R10 field max", {18'd0, got_sts[29:16]}, 32'd16383);
        check_frame("R10 wrap", 48'h0, 14'd16380);
        chk("R10 field wraps", {18'd0, got_sts[29:16]}, 32'd0);
    endtask

    task automatic t_busy();
        logic [47:0] a_ok;
        logic [47:0] a_bad;
        int          extra;
        clear_modes();
        a_ok  = 48'hCAFE_0000_BEEE;
        a_bad = 48'h0000_1111_2222;
        station_addr_i = a_ok;
        @(negedge clk);
        dst_addr_i = a_ok; frame_len_i = 14'd200; start_i = 1;
        @(negedge clk);
        dst_addr_i = a_bad; frame_len_i = 14'd300;
        repeat (3) @(negedge clk);
        start_i = 0;
        got_lat = 4;
        while (!done_o && got_lat < 40) begin
            @(negedge clk);
            got_lat++;
        end
        chk("R11 latency unchanged", got_lat, 8);
        chk("R11 forward of first", {31'd0, forward_o}, 32'd1);
        chk("R11 status of first", status_o, model_status(a_ok, 14'd200, 1'b1));
        extra = 0;
        repeat (12) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R11 no extra done", extra, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_promisc();
        t_bcast();
        t_perfect();
        t_inverse();
        t_mcast();
        t_hash();
        t_rxall();
        t_len();
        t_busy();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule